// File: doc/BRIEF.md
# Hart Interrupt Delivery Context

This block is the delivery end of a wired-mode interrupt controller, serving exactly one hart. Each cycle it looks at every interrupt source and keeps those that are pending, enabled and aimed at this hart. It then picks the most urgent of them after applying a priority threshold. The result drives the hart's external interrupt request and is shown as a "top" value. A claim read returns that value and asks the pending-bit owner to clear the claimed source.

Source sampling and pending storage live outside this block. The block receives the pending, enabled, target-hart, priority, trigger-mode and raw-input vectors, plus the domain-wide interrupt enable. Software reaches the context through five word registers in a 32-byte window.

A smaller priority number is more urgent. The claim path knows about level triggering: a level source whose line is still active is not cleared, so it stays pending straight away.

Top module: `hart_irq_ctx`

## Requirements
- R1: Among sources 1..NSRC that are pending, enabled and targeted at hart CTX_HART, the source with the smallest effective priority number is selected. On equal priority the lowest source number wins.
- R2: With threshold 0 no source is masked. With a nonzero threshold T, any source whose effective priority is T or larger is not a candidate.
- R3: The top value carries the selected source number in bits 25:16 and its effective priority in bits 7:0, with all other bits zero. It is all zero when there is no candidate. It appears on top_o and is returned by a read at offset 0x18.
- R4: The effective priority of a source is its raw priority field masked to the low PRIO_W bits. A masked value of 0 is treated as 1.
- R5: irq_o is high exactly when dom_ie_i is 1, the delivery-enable bit is 1, and either the force bit is 1 or the top value is nonzero.
- R6: A read at offset 0x1C (claim) returns the top value. In the same cycle it pulses clr_pend_o for the selected source only. No pulse is given if that source has mode 6 (level-high) with its input at 1, or mode 7 (level-low) with its input at 0.
- R7: A claim read with no candidate returns 0 and clears the force bit at the following clock edge.
- R8: Offset 0x00 holds delivery-enable in bit 0, offset 0x04 holds force in bit 0, and offset 0x08 holds the threshold in bits PRIO_W-1:0. All three read back, and all reset to zero. Writes to 0x18 and 0x1C change nothing.
- R9: A source whose target hart differs from CTX_HART never affects the top value, irq_o or clr_pend_o.
- R10: The claim side effect occurs once per one-cycle read strobe at 0x1C. Reads of any other offset never pulse clr_pend_o or change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_ie_i | input | 1 | Domain-wide interrupt enable |
| pend_i | input | NSRC | Pending bit per source (index = source number) |
| en_i | input | NSRC | Enable bit per source |
| tgt_i | input | NSRC x HART_W | Target hart index per source |
| prio_i | input | NSRC x RAW_W | Raw priority field per source |
| mode_i | input | NSRC x 3 | Trigger mode per source (6 level-high, 7 level-low) |
| lvl_i | input | NSRC | Current raw input level per source |
| reg_en_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 5 | Byte offset in the context window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| top_o | output | 32 | Current top value |
| irq_o | output | 1 | External interrupt request to the hart |
| clr_pend_o | output | NSRC | One-cycle clear-pending request from a claim |

## Verification
Several properties are checked by assertions on every cycle:
- a clear request is at most one-hot, is caused only by a claim strobe, and names only a source that is pending and enabled;
- a reported top value always respects a nonzero threshold;
- irq_o is never high without domain and delivery enable;
- an empty claim leaves force clear;
- the selector never reports a winner while a strictly more urgent candidate exists.

Other behaviours can only be shown by the bench's scenarios: tie-breaking by source number, the zero-to-one priority substitution, the exact field placement of the top value, and the level re-arm choice for each mode and input pairing. The bench compares these against a reference model over random source populations.

// File: rtl/hctx_pkg.sv
`timescale 1ns/1ps
package hctx_pkg;
    // Register offsets inside the 32-byte context window
    localparam logic [4:0] OFF_DELIV = 5'h00;
    localparam logic [4:0] OFF_FORCE = 5'h04;
    localparam logic [4:0] OFF_THR   = 5'h08;
    localparam logic [4:0] OFF_TOP   = 5'h18;
    localparam logic [4:0] OFF_CLAIM = 5'h1C;

    // Trigger modes that re-arm on claim
    localparam logic [2:0] MODE_LVL_HI = 3'd6;
    localparam logic [2:0] MODE_LVL_LO = 3'd7;

    // Field positions of the top value
    localparam int TOP_ID_LSB = 16;
    localparam int TOP_ID_W   = 10;
    localparam int TOP_PR_W   = 8;
endpackage

// File: rtl/ctx_filter.sv
`timescale 1ns/1ps
module ctx_filter #(
    parameter int NSRC     = 16,
    parameter int HART_W   = 4,
    parameter int RAW_W    = 8,
    parameter int PRIO_W   = 3,
    parameter int CTX_HART = 2
) (
    input  logic [NSRC:1]                pend_i,
    input  logic [NSRC:1]                en_i,
    input  logic [NSRC:1][HART_W-1:0]    tgt_i,
    input  logic [NSRC:1][RAW_W-1:0]     prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [NSRC:1]                cand_o,
    output logic [NSRC:1][PRIO_W-1:0]    eprio_o
);
    localparam logic [HART_W-1:0] MY_HART = HART_W'(CTX_HART);
    localparam logic [PRIO_W-1:0] PRIO_ONE = PRIO_W'(1);

    for (genvar s = 1; s <= NSRC; s++) begin : g_src
        logic [PRIO_W-1:0] masked;
        logic              ours;
        logic              below_thr;

        assign masked      = prio_i[s][PRIO_W-1:0];
        assign eprio_o[s]  = (masked == '0) ? PRIO_ONE : masked;
        assign ours        = (tgt_i[s] == MY_HART);
        assign below_thr   = (thr_i == '0) || (eprio_o[s] < thr_i);
        assign cand_o[s]   = pend_i[s] & en_i[s] & ours & below_thr;

        if (RAW_W > PRIO_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^prio_i[s][RAW_W-1:PRIO_W];
        end
    end
endmodule

// File: rtl/ctx_best_tree.sv
`timescale 1ns/1ps
module ctx_best_tree #(
    parameter int NSRC   = 16,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC:1]                cand_i,
    input  logic [NSRC:1][PRIO_W-1:0]    prio_i,
    output logic                         best_vld_o,
    output logic [ID_W-1:0]              best_id_o,
    output logic [PRIO_W-1:0]            best_prio_o
);
    localparam int LVLS  = (NSRC > 1) ? $clog2(NSRC) : 0;
    localparam int LEAFS = 1 << LVLS;
    localparam int NODES = 2 * LEAFS - 1;

    logic              nv [NODES];
    logic [ID_W-1:0]   nid[NODES];
    logic [PRIO_W-1:0] np [NODES];

    // Leaves: leaf i is source i+1; left-to-right order is ascending source number
    for (genvar i = 0; i < LEAFS; i++) begin : g_leaf
        if (i + 1 <= NSRC) begin : g_real
            assign nv [LEAFS-1+i] = cand_i[i+1];
            assign nid[LEAFS-1+i] = ID_W'(i + 1);
            assign np [LEAFS-1+i] = prio_i[i+1];
        end else begin : g_pad
            assign nv [LEAFS-1+i] = 1'b0;
            assign nid[LEAFS-1+i] = '0;
            assign np [LEAFS-1+i] = '0;
        end
    end

    // Internal nodes: right child wins only with a strictly smaller number
    for (genvar k = 0; k < LEAFS - 1; k++) begin : g_node
        logic take_r;
        assign take_r  = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] < np[2*k+1]));
        assign nv [k]  = nv[2*k+1] | nv[2*k+2];
        assign nid[k]  = take_r ? nid[2*k+2] : nid[2*k+1];
        assign np [k]  = take_r ? np [2*k+2] : np [2*k+1];
    end

    assign best_vld_o  = nv[0];
    assign best_id_o   = nid[0];
    assign best_prio_o = np[0];

    // Checker: no candidate is strictly more urgent than the reported winner
    logic better_seen;
    logic winner_is_cand;
    always_comb begin
        better_seen    = 1'b0;
        winner_is_cand = 1'b0;
        for (int s = 1; s <= NSRC; s++) begin
            if (cand_i[s] && (prio_i[s] < best_prio_o)) better_seen = 1'b1;
            if (cand_i[s] && (ID_W'(s) == best_id_o) && (prio_i[s] == best_prio_o))
                winner_is_cand = 1'b1;
        end
    end

    // R1
    best_is_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        best_vld_o |-> (!better_seen && winner_is_cand));
    // R1
    empty_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_i == '0) |-> !best_vld_o);
endmodule

// File: rtl/hart_irq_ctx.sv
`timescale 1ns/1ps
module hart_irq_ctx
    import hctx_pkg::*;
#(
    parameter int NSRC     = 16,
    parameter int HART_W   = 4,
    parameter int RAW_W    = 8,
    parameter int PRIO_W   = 3,
    parameter int CTX_HART = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dom_ie_i,
    input  logic [NSRC:1]               pend_i,
    input  logic [NSRC:1]               en_i,
    input  logic [NSRC:1][HART_W-1:0]   tgt_i,
    input  logic [NSRC:1][RAW_W-1:0]    prio_i,
    input  logic [NSRC:1][2:0]          mode_i,
    input  logic [NSRC:1]               lvl_i,
    input  logic                        reg_en_i,
    input  logic                        reg_we_i,
    input  logic [4:0]                  reg_addr_i,
    input  logic [31:0]                 reg_wdata_i,
    output logic [31:0]                 reg_rdata_o,
    output logic [31:0]                 top_o,
    output logic                        irq_o,
    output logic [NSRC:1]               clr_pend_o
);
    localparam int ID_W = $clog2(NSRC + 1);

    typedef struct packed {
        logic              deliv;
        logic              frc;
        logic [PRIO_W-1:0] thr;
    } ctx_st_t;

    ctx_st_t st_d, st_q;

    logic [NSRC:1]              cand;
    logic [NSRC:1][PRIO_W-1:0]  eprio;
    logic                       best_vld;
    logic [ID_W-1:0]            best_id;
    logic [PRIO_W-1:0]          best_prio;
    logic [NSRC:1]              rearm;
    logic                       wr_stb, rd_stb, claim_stb;
    logic [31:0]                top_val;
    logic                       unused_wd;

    assign unused_wd = ^reg_wdata_i[31:1];

    ctx_filter #(
        .NSRC(NSRC), .HART_W(HART_W), .RAW_W(RAW_W),
        .PRIO_W(PRIO_W), .CTX_HART(CTX_HART)
    ) u_filter (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .tgt_i   (tgt_i),
        .prio_i  (prio_i),
        .thr_i   (st_q.thr),
        .cand_o  (cand),
        .eprio_o (eprio)
    );

    ctx_best_tree #(
        .NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_tree (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_i      (cand),
        .prio_i      (eprio),
        .best_vld_o  (best_vld),
        .best_id_o   (best_id),
        .best_prio_o (best_prio)
    );

    // Level sources whose line is still active stay pending after a claim
    for (genvar s = 1; s <= NSRC; s++) begin : g_rearm
        assign rearm[s] = ((mode_i[s] == MODE_LVL_HI) &&  lvl_i[s]) ||
                          ((mode_i[s] == MODE_LVL_LO) && !lvl_i[s]);
    end

    assign wr_stb    = reg_en_i &  reg_we_i;
    assign rd_stb    = reg_en_i & ~reg_we_i;
    assign claim_stb = rd_stb && (reg_addr_i == OFF_CLAIM);

    always_comb begin
        top_val = '0;
        if (best_vld) begin
            top_val[TOP_ID_LSB +: ID_W] = best_id;
            top_val[PRIO_W-1:0]         = best_prio;
        end
    end

    // Next-state, read data and claim requests
    always_comb begin
        st_d        = st_q;
        reg_rdata_o = '0;
        clr_pend_o  = '0;

        if (wr_stb) begin
            unique case (reg_addr_i)
                OFF_DELIV: st_d.deliv = reg_wdata_i[0];
                OFF_FORCE: st_d.frc   = reg_wdata_i[0];
                OFF_THR:   st_d.thr   = reg_wdata_i[PRIO_W-1:0];
                default:   ;
            endcase
        end

        if (rd_stb) begin
            unique case (reg_addr_i)
                OFF_DELIV: reg_rdata_o = {31'd0, st_q.deliv};
                OFF_FORCE: reg_rdata_o = {31'd0, st_q.frc};
                OFF_THR:   reg_rdata_o = 32'(st_q.thr);
                OFF_TOP:   reg_rdata_o = top_val;
                OFF_CLAIM: reg_rdata_o = top_val;
                default:   reg_rdata_o = '0;
            endcase
        end

        if (claim_stb) begin
            if (!best_vld) begin
                st_d.frc = 1'b0;
            end else begin
                for (int s = 1; s <= NSRC; s++) begin
                    if ((ID_W'(s) == best_id) && !rearm[s]) clr_pend_o[s] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_o = top_val;
    assign irq_o = dom_ie_i & st_q.deliv & (st_q.frc | best_vld);

    // R6
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pend_o));
    // R10
    clr_needs_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_o != '0) |-> (reg_en_i && !reg_we_i && reg_addr_i == OFF_CLAIM));
    // R6
    clr_is_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_o & ~(pend_i & en_i)) == '0);
    // R7
    force_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_stb && top_o == '0) |=> !st_q.frc);
    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (dom_ie_i && st_q.deliv));
    // R2
    thr_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.thr != '0 && top_o != '0) |-> (top_o[PRIO_W-1:0] < st_q.thr));
    // R8
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && reg_addr_i == OFF_THR) |=> $stable(st_q.thr));
endmodule

// File: tb/sim_hart_irq_ctx.sv
`timescale 1ns/1ps
module sim_hart_irq_ctx;
    localparam int NS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                 dom_ie;
    logic [NS:1]          pend, en, lvl;
    logic [NS:1][3:0]     tgt;
    logic [NS:1][7:0]     praw;
    logic [NS:1][2:0]     mode;
    logic                 reg_en, reg_we;
    logic [4:0]           reg_addr;
    logic [31:0]          reg_wdata, rdata, top;
    logic                 irq;
    logic [NS:1]          clr;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench-side model of the context registers
    logic       m_deliv, m_frc;
    logic [2:0] m_thr;

    hart_irq_ctx #(.NSRC(NS), .HART_W(4), .RAW_W(8), .PRIO_W(3), .CTX_HART(2)) u0 (
        .clk(clk), .rst_n(rst_n), .dom_ie_i(dom_ie),
        .pend_i(pend), .en_i(en), .tgt_i(tgt), .prio_i(praw),
        .mode_i(mode), .lvl_i(lvl),
        .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
        .top_o(top), .irq_o(irq), .clr_pend_o(clr)
    );

    function automatic logic [31:0] model_top(input logic [2:0] thr);
        int best = -1;
        int bp = 99;
        for (int s = 1; s <= NS; s++) begin
            int p;
            if (!(pend[s] && en[s] && tgt[s] == 4'd2)) continue;
            p = int'(praw[s][2:0]);
            if (p == 0) p = 1;
            if (thr != 0 && p >= int'(thr)) continue;
            if (p < bp) begin best = s; bp = p; end
        end
        if (best < 0) return 32'd0;
        return (32'(best) << 16) | 32'(bp);
    endfunction

    function automatic logic model_irq();
        return dom_ie & m_deliv & (m_frc | (model_top(m_thr) != 0));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d, output logic [NS:1] c);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1;
        d = rdata; c = clr;
        @(negedge clk);
        reg_en = 0;
    endtask

    task automatic clear_src();
        pend = '0; en = '0; lvl = '0; tgt = '0; praw = '0; mode = '0;
    endtask

    task automatic settle_chk(input string req);
        @(negedge clk); #1;
        chk(req, top, model_top(m_thr));
        chk(req, {31'd0, irq}, {31'd0, model_irq()});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NS:1] c, ec;
        void'($urandom(32'd4242));
        dom_ie = 0; reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        clear_src();
        m_deliv = 0; m_frc = 0; m_thr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R8 reset state
        rd_reg(5'h00, d, c); chk("R8 deliv reset", d, 0);
        rd_reg(5'h04, d, c); chk("R8 force reset", d, 0);
        rd_reg(5'h08, d, c); chk("R8 thr reset", d, 0);
        chk("R5 irq reset", {31'd0, irq}, 0);
        chk("R3 top reset", top, 0);

        wr_reg(5'h00, 1); m_deliv = 1; dom_ie = 1;
        rd_reg(5'h00, d, c); chk("R8 deliv readback", d, 1);

        // R1 tie: sources 3 and 5 at priority 2 -> 3
        @(negedge clk);
        pend[3] = 1; en[3] = 1; tgt[3] = 2; praw[3] = 8'd2;
        pend[5] = 1; en[5] = 1; tgt[5] = 2; praw[5] = 8'd2;
        settle_chk("R1 tie");
        chk("R1 tie id", top, (32'd3 << 16) | 32'd2);
        rd_reg(5'h18, d, c);
        chk("R3 top read", d, (32'd3 << 16) | 32'd2);
        chk("R10 top read no clear", 32'(c), 0);

        // R9 source for another hart with better priority is ignored
        @(negedge clk);
        pend[1] = 1; en[1] = 1; tgt[1] = 5; praw[1] = 8'd1;
        settle_chk("R9 other hart");
        chk("R9 other hart id", top, (32'd3 << 16) | 32'd2);

        // R4 raw 0x08 masks to 0 -> treated as 1
        @(negedge clk);
        pend[7] = 1; en[7] = 1; tgt[7] = 2; praw[7] = 8'h08;
        settle_chk("R4 zero->one");
        chk("R4 zero->one id", top, (32'd7 << 16) | 32'd1);
        @(negedge clk); praw[7] = 8'hFD;
        settle_chk("R4 mask");
        chk("R4 mask id", top, (32'd3 << 16) | 32'd2);

        // R2 threshold 2 excludes priority 2, nothing remains
        wr_reg(5'h08, 32'hFFFF_FFFA); m_thr = 3'd2;
        rd_reg(5'h08, d, c); chk("R8 thr readback", d, 2);
        settle_chk("R2 threshold");
        chk("R2 all masked", top, 0);
        wr_reg(5'h08, 0); m_thr = 0;
        settle_chk("R2 thr zero");

        // R5 gating
        @(negedge clk); dom_ie = 0;
        settle_chk("R5 dom_ie off");
        @(negedge clk); dom_ie = 1;
        wr_reg(5'h00, 0); m_deliv = 0;
        settle_chk("R5 deliv off");
        wr_reg(5'h00, 1); m_deliv = 1;
        clear_src();
        wr_reg(5'h04, 1); m_frc = 1;
        settle_chk("R5 force only");
        chk("R5 force only irq", {31'd0, irq}, 1);

        // R7 empty claim clears force
        rd_reg(5'h1C, d, c); m_frc = 0;
        chk("R7 empty claim", d, 0);
        chk("R7 empty claim clr", 32'(c), 0);
        rd_reg(5'h04, d, c); chk("R7 force cleared", d, 0);
        settle_chk("R7 irq low");

        // R6 edge source: claim clears it
        @(negedge clk);
        pend[9] = 1; en[9] = 1; tgt[9] = 2; praw[9] = 8'd3; mode[9] = 3'd4;
        rd_reg(5'h1C, d, c);
        ec = '0; ec[9] = 1;
        chk("R6 claim value", d, (32'd9 << 16) | 32'd3);
        chk("R6 claim clear", 32'(c), 32'(ec));
        // R6 level-high, input high: no clear
        @(negedge clk); mode[9] = 3'd6; lvl[9] = 1;
        rd_reg(5'h1C, d, c);
        chk("R6 lvl-hi rearm", 32'(c), 0);
        // R6 level-low, input low: no clear
        @(negedge clk); mode[9] = 3'd7; lvl[9] = 0;
        rd_reg(5'h1C, d, c);
        chk("R6 lvl-lo rearm", 32'(c), 0);
        // R6 level-low, input high: clear
        @(negedge clk); lvl[9] = 1;
        rd_reg(5'h1C, d, c);
        chk("R6 lvl-lo inactive", 32'(c), 32'(ec));
        // R10 force set + claim with candidate keeps force; top read no clear
        wr_reg(5'h04, 1); m_frc = 1;
        rd_reg(5'h1C, d, c);
        rd_reg(5'h04, d, c); chk("R10 force kept", d, 1);
        rd_reg(5'h08, d, c); chk("R10 other read no clear", 32'(c), 0);

        // R8 writes to top/claim offsets are ignored
        wr_reg(5'h18, 32'hFFFF_FFFF);
        wr_reg(5'h1C, 32'hFFFF_FFFF);
        rd_reg(5'h08, d, c); chk("R8 thr after ro write", d, 0);
        rd_reg(5'h00, d, c); chk("R8 deliv after ro write", d, 1);
        rd_reg(5'h04, d, c); chk("R8 force after ro write", d, 1);
        wr_reg(5'h04, 0); m_frc = 0;
        clear_src();

        // R1 R2 R3 R5 random populations
        for (int it = 0; it < 400; it++) begin
            if (it % 20 == 0) begin
                logic [2:0] t;
                t = 3'($urandom_range(0, 7));
                wr_reg(5'h08, 32'(t)); m_thr = t;
            end
            @(negedge clk);
            dom_ie = ($urandom_range(0, 7) != 0);
            for (int s = 1; s <= NS; s++) begin
                pend[s] = 1'($urandom_range(0, 1));
                en[s]   = 1'($urandom_range(0, 1));
                tgt[s]  = 4'($urandom_range(0, 3));
                praw[s] = 8'($urandom_range(0, 255));
            end
            #1;
            chk("R1 R2 R3 random top", top, model_top(m_thr));
            chk("R5 random irq", {31'd0, irq}, {31'd0, model_irq()});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule